// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block turns a virtual page number into a physical frame number by walking a hashed page table. The table sits in a word-addressed memory. The block folds the page number into a 6-bit bucket index and reads that bucket's head pointer. It then follows the collision chain one element at a time until an element's page field equals the requested page. Software builds and maintains the table. The walker only reads it, through one read port whose latency varies and which returns each read with a one-cycle valid pulse.

A requester hands over a page number with a valid/ready handshake. Only one walk is in progress at a time. The answer is a frame number and a 2-bit fault code: 0 means translated, 1 means the page is not in the table, and 2 means the chain is longer than the walk limit. The response stays on the outputs until the requester takes it.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for a request.
- `ST_HEAD_RD` and `ST_HEAD_WT`: issue the bucket head read, then wait for it.
- `ST_PAGE_RD` and `ST_PAGE_WT`: read an element's page word, then wait for it.
- `ST_FRAME_RD` and `ST_FRAME_WT`: read the frame word of a matching element, then wait for it.
- `ST_LINK_RD` and `ST_LINK_WT`: read the next pointer of an element that did not match, then wait for it.
- `ST_REPLY`: holds the response.

Its transitions are:
- accept: `ST_IDLE` to `ST_HEAD_RD`.
- issue: each `*_RD` state to its `*_WT` state.
- empty bucket: `ST_HEAD_WT` to `ST_REPLY`.
- first element: `ST_HEAD_WT` to `ST_PAGE_RD`.
- hit: `ST_PAGE_WT` to `ST_FRAME_RD`.
- miss: `ST_PAGE_WT` to `ST_LINK_RD`.
- found: `ST_FRAME_WT` to `ST_REPLY`.
- chain end: `ST_LINK_WT` to `ST_REPLY`.
- limit: `ST_LINK_WT` to `ST_REPLY`.
- follow: `ST_LINK_WT` to `ST_PAGE_RD`.
- retire: `ST_REPLY` to `ST_IDLE`.

Top module: `hpt_walker`

## Requirements
- R1: The bucket index is `vpn[5:0] ^ vpn[11:6]`. The first read of every walk goes to address `TBL_BASE + index`, where `TBL_BASE` defaults to 0.
- R2: A head pointer of 0 ends the walk after that single read, with fault code 1 (not found) and frame 0.
- R3: An element at address p keeps its page number in word p, its frame number in word p+1 and its next pointer in word p+2. The page word is compared in its low 12 bits, the frame is taken from the low 10 bits of its word, and a pointer is taken from the low 12 bits of its word.
- R4: When an element's page matches, the walker reads that element's frame word and responds with fault code 0 and that frame. It makes no further reads, so a match at chain position k costs 2k+1 reads.
- R5: When an element's page does not match, the walker skips its frame word and reads only its next pointer. A next pointer of 0 gives fault code 1 and frame 0, after 2k+1 reads for k elements.
- R6: At most 16 elements are examined, and a match on the 16th still translates. If the 16th element does not match and its next pointer is nonzero, the walker responds with fault code 2 and frame 0 after 33 reads, which also stops a circular chain.
- R7: `mem_rd_en` is a one-cycle pulse, and no further read is issued until `mem_rd_valid` has returned the previous one.
- R8: `req_ready` is high only when idle. It drops in the cycle after acceptance and stays low until the response has been taken.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_frame` and `rsp_fault` hold their values.
- R10: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vpn | input | 12 | Virtual page number to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_frame | output | 10 | Frame number (0 on a fault) |
| rsp_fault | output | 2 | 0 = translated, 1 = not found, 2 = walk limit |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_rd_addr | output | 12 | Word address of the read |
| mem_rd_valid | input | 1 | One-cycle pulse returning read data |
| mem_rd_data | input | 16 | Read data word |

## Verification
The hardest situation to reach from the ports is the boundary of the walk limit. It takes a chain of exactly 16 elements, or of 17, or one that loops back on itself, and no well-formed table arises that way by chance. The bench builds such chains directly in its memory model, all within one bucket. It then asks for the 16th element, for the 17th, and for an absent page, and it also walks a single element that points to itself. It compares the fault codes and the exact read counts with the values derived from R4 to R6. A sweep over half the page-number space covers empty buckets, hits at different chain depths and misses, with read latency and response back-pressure varied from one request to the next.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEAD_RD,
        ST_HEAD_WT,
        ST_PAGE_RD,
        ST_PAGE_WT,
        ST_FRAME_RD,
        ST_FRAME_WT,
        ST_LINK_RD,
        ST_LINK_WT,
        ST_REPLY
    } walk_state_t;

    localparam logic [1:0] FLT_NONE  = 2'd0;
    localparam logic [1:0] FLT_ABSENT = 2'd1;
    localparam logic [1:0] FLT_LIMIT = 2'd2;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int VPN_W = 12,
    parameter int IDX_W = 6
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx
);
    generate
        if (VPN_W >= 2 * IDX_W) begin : g_fold
            assign idx = vpn[IDX_W-1:0] ^ vpn[2*IDX_W-1:IDX_W];
        end else begin : g_low
            assign idx = vpn[IDX_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/hpt_hop_ctr.sv
module hpt_hop_ctr #(
    parameter int MAX_HOPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic at_limit
);
    localparam int CNT_W = $clog2(MAX_HOPS + 1);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (step && !at_limit) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign at_limit = (count_q == CNT_W'(MAX_HOPS));

    // R6: the element count never goes past the walk limit
    p_hop_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(MAX_HOPS));

    // R6: a step only ever raises the count by one
    p_hop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !at_limit) |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int VPN_W    = 12,
    parameter int FRAME_W  = 10,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int IDX_W    = 6,
    parameter int MAX_HOPS = 16,
    parameter logic [ADDR_W-1:0] TBL_BASE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VPN_W-1:0]   req_vpn,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [FRAME_W-1:0] rsp_frame,
    output logic [1:0]         rsp_fault,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [DATA_W-1:0]  mem_rd_data
);
    localparam logic [ADDR_W-1:0] OFS_FRAME = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_LINK  = ADDR_W'(2);

    walk_state_t state_q, state_d;

    logic [VPN_W-1:0]   vpn_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic [FRAME_W-1:0] frame_q;
    logic [1:0]         fault_q;
    logic [IDX_W-1:0]   bucket;
    logic [ADDR_W-1:0]  ptr_in;
    logic               page_hit;
    logic               hop_at_limit;
    logic               hop_clear;
    logic               hop_step;
    logic               accept;

    assign ptr_in   = mem_rd_data[ADDR_W-1:0];
    assign page_hit = (mem_rd_data[VPN_W-1:0] == vpn_q);
    assign accept   = (state_q == ST_IDLE) && req_valid;

    hpt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) hash_i (
        .vpn (vpn_q),
        .idx (bucket)
    );

    assign hop_clear = accept;
    assign hop_step  = mem_rd_valid && (ptr_in != '0) &&
                       ((state_q == ST_HEAD_WT) || (state_q == ST_LINK_WT));

    hpt_hop_ctr #(.MAX_HOPS(MAX_HOPS)) hops_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hop_clear),
        .step     (hop_step),
        .at_limit (hop_at_limit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_HEAD_RD;
            ST_HEAD_RD:  state_d = ST_HEAD_WT;
            ST_HEAD_WT:  if (mem_rd_valid)
                             state_d = (ptr_in == '0) ? ST_REPLY : ST_PAGE_RD;
            ST_PAGE_RD:  state_d = ST_PAGE_WT;
            ST_PAGE_WT:  if (mem_rd_valid)
                             state_d = page_hit ? ST_FRAME_RD : ST_LINK_RD;
            ST_FRAME_RD: state_d = ST_FRAME_WT;
            ST_FRAME_WT: if (mem_rd_valid) state_d = ST_REPLY;
            ST_LINK_RD:  state_d = ST_LINK_WT;
            ST_LINK_WT:  if (mem_rd_valid)
                             state_d = ((ptr_in == '0) || hop_at_limit) ? ST_REPLY
                                                                        : ST_PAGE_RD;
            ST_REPLY:    if (rsp_ready) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q   <= '0;
            ptr_q   <= '0;
            frame_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    vpn_q   <= req_vpn;
                    frame_q <= '0;
                    fault_q <= FLT_NONE;
                end
                ST_HEAD_WT: if (mem_rd_valid) begin
                    ptr_q <= ptr_in;
                    if (ptr_in == '0) fault_q <= FLT_ABSENT;
                end
                ST_FRAME_WT: if (mem_rd_valid) begin
                    frame_q <= mem_rd_data[FRAME_W-1:0];
                end
                ST_LINK_WT: if (mem_rd_valid) begin
                    ptr_q <= ptr_in;
                    if (ptr_in == '0)      fault_q <= FLT_ABSENT;
                    else if (hop_at_limit) fault_q <= FLT_LIMIT;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        rsp_valid   = 1'b0;
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_HEAD_RD:  begin mem_rd_en = 1'b1; mem_rd_addr = TBL_BASE + ADDR_W'(bucket); end
            ST_PAGE_RD:  begin mem_rd_en = 1'b1; mem_rd_addr = ptr_q; end
            ST_FRAME_RD: begin mem_rd_en = 1'b1; mem_rd_addr = ptr_q + OFS_FRAME; end
            ST_LINK_RD:  begin mem_rd_en = 1'b1; mem_rd_addr = ptr_q + OFS_LINK; end
            ST_REPLY:    rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign rsp_frame = frame_q;
    assign rsp_fault = fault_q;

    // R7: a read request lasts one cycle
    p_read_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R8: nothing is accepted while a response is pending
    p_busy_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R8: acceptance starts the head read on the next cycle
    p_accept_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_en && !req_ready));

    // R9: a pending response holds still
    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_frame) && $stable(rsp_fault)));

    // R2 / R6: a faulted response carries frame zero
    p_fault_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault != FLT_NONE)) |-> (rsp_frame == '0));
endmodule

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_vpn = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [9:0]  rsp_frame;
    logic [1:0]  rsp_fault;
    logic        mem_rd_en;
    logic [11:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = '0;

    always #2 clk = ~clk;

    hpt_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_frame(rsp_frame), .rsp_fault(rsp_fault),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    logic [15:0] mem [0:4095];
    int          total = 0;
    int          bad = 0;
    int          rd_count = 0;
    int          proto_err = 0;
    logic [11:0] first_addr = '0;
    bit          pend = 0;
    int          cnt = 0;
    logic [11:0] cap_addr = '0;
    int          free_ptr = 64;
    int          cycles = 0;
    bit          hung = 0;

    // memory model, variable latency of 0..2 extra cycles
    always @(negedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_rd_en) begin
            if (pend) proto_err++;
            pend = 1;
            cnt = rd_count % 3;
            cap_addr = mem_rd_addr;
            if (rd_count == 0) first_addr = mem_rd_addr;
            rd_count++;
        end else if (pend) begin
            if (cnt == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem[cap_addr];
                pend = 0;
            end else begin
                cnt--;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !hung) hung = 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] bkt(input logic [11:0] v);
        return v[5:0] ^ v[11:6];
    endfunction

    function automatic logic [11:0] vpn_in(input int b, input int a);
        logic [5:0] hi;
        hi = 6'(a);
        return {hi, hi ^ 6'(b)};
    endfunction

    task automatic add_entry(input logic [11:0] v, input logic [9:0] f);
        logic [5:0] h;
        h = bkt(v);
        mem[free_ptr]     = 16'h5000 | 16'(v);
        mem[free_ptr + 1] = 16'hA400 | 16'(f);
        mem[free_ptr + 2] = 16'hC000 | mem[h][11:0];
        mem[h]            = 16'h3000 | 16'(free_ptr);
        free_ptr += 3;
    endtask

    function automatic void ref_walk(input logic [11:0] v, output logic [9:0] f,
                                     output logic [1:0] flt, output int nr);
        logic [11:0] p;
        int n;
        bit done;
        f = '0; flt = 2'd1; nr = 1; n = 0; done = 0;
        p = mem[bkt(v)][11:0];
        for (int i = 0; i < 40; i++) begin
            if (!done) begin
                if (p == 0) begin
                    done = 1;
                end else if (n == 16) begin
                    flt = 2'd2; done = 1;
                end else begin
                    n++; nr++;
                    if (mem[p][11:0] == v) begin
                        nr++; f = mem[p + 1][9:0]; flt = 2'd0; done = 1;
                    end else begin
                        nr++; p = mem[p + 2][11:0];
                    end
                end
            end
        end
    endfunction

    task automatic run_query(input logic [11:0] v, input int hold,
                             output logic [9:0] f, output logic [1:0] flt,
                             output int nr, output logic [11:0] fa);
        int guard;
        bit busy_ok;
        guard = 0;
        while (!req_ready && guard < 400) begin @(negedge clk); guard++; end
        rd_count = 0;
        req_valid = 1'b1;
        req_vpn = v;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R8 ready low after accept", int'(req_ready), 0);
        busy_ok = 1;
        guard = 0;
        while (!rsp_valid && guard < 400 && !hung) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            guard++;
        end
        check(busy_ok, "R8 ready low during walk", int'(busy_ok), 1);
        check(rsp_valid, "watchdog response", int'(rsp_valid), 1);
        f = rsp_frame; flt = rsp_fault; nr = rd_count; fa = first_addr;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(rsp_valid && rsp_frame == f && rsp_fault == flt,
                  "R9 response held", int'(rsp_frame), int'(f));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic expect_walk(input logic [11:0] v, input int hold, input string tag,
                               input logic [9:0] ef, input logic [1:0] eflt, input int enr);
        logic [9:0] f; logic [1:0] flt; int nr; logic [11:0] fa;
        run_query(v, hold, f, flt, nr, fa);
        check(fa == 12'(bkt(v)), {tag, " R1 head address"}, int'(fa), int'(bkt(v)));
        check(flt == eflt, {tag, " fault"}, int'(flt), int'(eflt));
        check(f == ef, {tag, " frame"}, int'(f), int'(ef));
        check(nr == enr, {tag, " read count"}, nr, enr);
    endtask

    initial begin
        logic [9:0] ef; logic [1:0] eflt; int enr;
        logic [11:0] v;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(req_ready == 1'b1, "R10 req_ready", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R10 rsp_valid", int'(rsp_valid), 0);
        check(mem_rd_en == 1'b0, "R10 mem_rd_en", int'(mem_rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: empty bucket, one read
        expect_walk(12'h123, 2, "R2 empty", 10'd0, 2'd1, 1);

        // R3 R4 R5: sweep
        for (int k = 0; k < 200; k++) begin
            v = 12'((k * 37) % 2048);
            add_entry(v, 10'((int'(v) * 7 + 3) % 1024));
        end
        for (int q = 0; q < 2048; q++) begin
            v = 12'(q);
            ref_walk(v, ef, eflt, enr);
            expect_walk(v, q % 3, (eflt == 0) ? "R4 sweep hit" : "R5 sweep miss", ef, eflt, enr);
            if (hung) break;
        end

        // R6: chain of 16 in bucket 5
        mem[5] = '0;
        for (int a = 16; a >= 1; a--) add_entry(vpn_in(5, a), 10'(100 + a));
        expect_walk(vpn_in(5, 16), 1, "R6 match at 16th", 10'(116), 2'd0, 33);
        expect_walk(vpn_in(5, 1), 0, "R4 match at 1st", 10'(101), 2'd0, 3);
        expect_walk(vpn_in(5, 40), 1, "R5 absent after 16", 10'd0, 2'd1, 33);
        add_entry(vpn_in(5, 17), 10'(117));
        expect_walk(vpn_in(5, 16), 2, "R6 limit at 17th", 10'd0, 2'd2, 33);
        expect_walk(vpn_in(5, 40), 0, "R6 limit absent", 10'd0, 2'd2, 33);
        expect_walk(vpn_in(5, 17), 1, "R4 head of long chain", 10'(117), 2'd0, 3);

        // R6: circular chain in bucket 9
        mem[3000] = 16'h5000 | 16'(vpn_in(9, 2));
        mem[3001] = 16'h0011;
        mem[3002] = 16'd3000;
        mem[9]    = 16'd3000;
        expect_walk(vpn_in(9, 3), 1, "R6 circular", 10'd0, 2'd2, 33);
        expect_walk(vpn_in(9, 2), 0, "R3 self-loop hit", 10'h011, 2'd0, 3);

        // R7: read protocol over the whole run
        check(proto_err == 0, "R7 overlapping reads", proto_err, 0);
        check(!hung, "watchdog", int'(hung), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule